// File: doc/BRIEF.md
# Programmable Periodic Tick Divider

This block divides a free-running clock down to a slow periodic event and records each event in a sticky flag. Software picks the period with a 7-bit control value. The upper three bits choose a power-of-two prescaler. The lower four bits choose a modulus from 1 to 16, and the modulus stage counts prescaler wraps. When the modulus stage completes, the flag sets. The flag drives an interrupt request while the interrupt is enabled, and it stays set until it is cleared by writing a one.

Three low-power and debug situations affect the counters, each in its own way:
- **Wait mode**, when its stop bit is set, holds both counters at their starting value.
- **Pseudo-stop**, when its run bit is clear, freezes both counters where they are.
- **Active debug**, when its stop bit is set, pauses both counters in the same way.

A control write always restarts the counting. Writing a prescale field of zero parks the block.

Top module: `period_tick_gen`

## Requirements
- R1: After reset, tickFlag and irqReq are 0 and the block is parked, because the control value resets to zero.
- R2: When the prescale field `ctrlData[6:4]` is 0, no period end occurs and tickFlag never sets, whatever the modulus field `ctrlData[3:0]` holds.
- R3: With a prescale field n from 1 to 7 and a modulus field m, the period is (m+1)·2^(BASE_LOG2+n) clock cycles. tickFlag rises exactly that many rising edges after the edge that captured the control write.
- R4: Every control write clears both counters, so the next period is counted in full from the writing edge, even when the value written is the same as before.
- R5: While waitMode and stopInWait are both 1, both counters are held at zero, and counting restarts from zero afterwards. With stopInWait at 0, waitMode has no effect.
- R6: While pseudoStop is 1 and runInPseudo is 0, both counters keep their values and counting resumes where it stopped. With runInPseudo at 1, pseudoStop has no effect.
- R7: While debugActive and stopInDebug are both 1, the counters pause without resetting. With stopInDebug at 0, debugActive has no effect.
- R8: tickFlag is sticky. A further period end keeps it at 1, and only flagClr driven to 1 on a cycle with no period end returns it to 0.
- R9: When a period end and flagClr fall on the same edge, tickFlag is 1 after that edge.
- R10: irqReq equals tickFlag AND irqEn at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived counting clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWr | input | 1 | Control write strobe |
| ctrlData | input | SEL_W+MOD_W (7) | Control value: prescale field in the upper bits, modulus field in the lower bits |
| flagClr | input | 1 | Write-one-to-clear request for tickFlag |
| irqEn | input | 1 | Interrupt enable |
| waitMode | input | 1 | The chip is in wait mode |
| stopInWait | input | 1 | Hold the counters at zero during wait mode |
| pseudoStop | input | 1 | The chip is in pseudo-stop mode |
| runInPseudo | input | 1 | Keep counting during pseudo-stop |
| debugActive | input | 1 | Active debug mode |
| stopInDebug | input | 1 | Pause the counters during active debug |
| tickFlag | output | 1 | Sticky period-end flag |
| irqReq | output | 1 | Interrupt request |

## Verification
The flag has two update paths that can act on the same edge: the period end, which sets the flag, and the software clear. The bench lets the flag set at one period end. It then drives flagClr across exactly the edge of the next period end, which it predicts from the programmed period, and expects the flag to read 1 afterwards. A lone clear on a quiet cycle is checked as well, to show that clearing works at all. A second collision is a control write landing on a cycle where the counters would otherwise advance. Every measured period starts on such a write, so the restart always wins over the advance.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Strobes from the mode control to the counting datapath
  typedef struct packed {
    logic init;     // force both counters to their starting value
    logic advance;  // step the counters this cycle
  } tickStrobe_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
(
  input  logic        ctrlWr,
  input  logic        selOn,
  input  logic        waitMode,
  input  logic        stopInWait,
  input  logic        pseudoStop,
  input  logic        runInPseudo,
  input  logic        debugActive,
  input  logic        stopInDebug,
  output tickStrobe_t strobe
);
  logic waitReset;
  logic freezeHold;

  assign waitReset  = waitMode & stopInWait;
  assign freezeHold = (pseudoStop & ~runInPseudo) | (debugActive & stopInDebug);

  always_comb begin
    // Priority: write restart, then the wait reset or parked state, then the holds
    strobe.init    = ctrlWr | waitReset | ~selOn;
    strobe.advance = ~strobe.init & ~freezeHold;
  end
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  parameter int SEL_W     = 3,
  parameter int MOD_W     = 4,
  localparam int CW       = SEL_W + MOD_W,
  localparam int PRE_W    = BASE_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic [CW-1:0]    ctrlData,
  input  tickStrobe_t      strobe,
  input  logic             flagClr,
  output logic             selOn,
  output logic             periodEnd,
  output logic             tickFlag,
  output logic [SEL_W-1:0] ctrlSel,
  output logic [MOD_W-1:0] ctrlMod,
  output logic [PRE_W-1:0] preCnt,
  output logic [MOD_W-1:0] modCnt
);
  localparam int SH_W = $clog2(PRE_W + 1) + 1;

  logic [SH_W-1:0] shAmt;
  logic [PRE_W:0]  preLimit;
  logic            preTerm;
  logic            modTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlSel <= '0;
      ctrlMod <= '0;
    end else if (ctrlWr) begin
      ctrlSel <= ctrlData[CW-1:MOD_W];
      ctrlMod <= ctrlData[MOD_W-1:0];
    end
  end

  assign selOn    = |ctrlSel;
  assign shAmt    = SH_W'(BASE_LOG2) + SH_W'(ctrlSel);
  assign preLimit = ((PRE_W + 1)'(1) << shAmt) - (PRE_W + 1)'(1);
  assign preTerm  = ({1'b0, preCnt} == preLimit);
  assign modTerm  = (modCnt == ctrlMod);
  assign periodEnd = strobe.advance & preTerm & modTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      modCnt <= '0;
    end else if (strobe.init) begin
      preCnt <= '0;
      modCnt <= '0;
    end else if (strobe.advance) begin
      if (preTerm) begin
        preCnt <= '0;
        modCnt <= modTerm ? '0 : modCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          tickFlag <= 1'b0;
    else if (periodEnd) tickFlag <= 1'b1;   // set wins over clear
    else if (flagClr)   tickFlag <= 1'b0;
  end
endmodule

// File: rtl/period_tick_gen.sv
module period_tick_gen
  import tick_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  parameter int SEL_W     = 3,
  parameter int MOD_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ctrlWr,
  input  logic [SEL_W+MOD_W-1:0] ctrlData,
  input  logic                   flagClr,
  input  logic                   irqEn,
  input  logic                   waitMode,
  input  logic                   stopInWait,
  input  logic                   pseudoStop,
  input  logic                   runInPseudo,
  input  logic                   debugActive,
  input  logic                   stopInDebug,
  output logic                   tickFlag,
  output logic                   irqReq
);
  localparam int PRE_W = BASE_LOG2 + (1 << SEL_W) - 1;

  tickStrobe_t      strobe;
  logic             selOn;
  logic             periodEnd;
  logic [SEL_W-1:0] ctrlSel;
  logic [MOD_W-1:0] ctrlMod;
  logic [PRE_W-1:0] preCnt;
  logic [MOD_W-1:0] modCnt;

  tick_ctrl ctrl_i (
    .ctrlWr      (ctrlWr),
    .selOn       (selOn),
    .waitMode    (waitMode),
    .stopInWait  (stopInWait),
    .pseudoStop  (pseudoStop),
    .runInPseudo (runInPseudo),
    .debugActive (debugActive),
    .stopInDebug (stopInDebug),
    .strobe      (strobe)
  );

  tick_datapath #(
    .BASE_LOG2 (BASE_LOG2),
    .SEL_W     (SEL_W),
    .MOD_W     (MOD_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .ctrlData  (ctrlData),
    .strobe    (strobe),
    .flagClr   (flagClr),
    .selOn     (selOn),
    .periodEnd (periodEnd),
    .tickFlag  (tickFlag),
    .ctrlSel   (ctrlSel),
    .ctrlMod   (ctrlMod),
    .preCnt    (preCnt),
    .modCnt    (modCnt)
  );

  assign irqReq = tickFlag & irqEn;
endmodule

// File: rtl/period_tick_chk.sv
module period_tick_chk #(
  parameter int PRE_W = 16,
  parameter int SEL_W = 3,
  parameter int MOD_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWr,
  input logic             flagClr,
  input logic             waitMode,
  input logic             stopInWait,
  input logic             pseudoStop,
  input logic             runInPseudo,
  input logic             debugActive,
  input logic             stopInDebug,
  input logic             periodEnd,
  input logic             tickFlag,
  input logic             irqReq,
  input logic [SEL_W-1:0] ctrlSel,
  input logic [MOD_W-1:0] ctrlMod,
  input logic [PRE_W-1:0] preCnt,
  input logic [MOD_W-1:0] modCnt
);
  // R2: a parked block never produces a period end
  p_parked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlSel == '0) |-> !periodEnd);

  // R3: the modulus stage never runs past its programmed limit
  p_mod_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    modCnt <= ctrlMod);

  // R4: a write leaves both counters at zero
  p_reinit_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (preCnt == '0) && (modCnt == '0));

  // R5: wait with its stop bit holds the counters at zero
  p_wait_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (waitMode && stopInWait) |=> (preCnt == '0) && (modCnt == '0));

  // R6: pseudo-stop without its run bit freezes the counters
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pseudoStop && !runInPseudo && !ctrlWr && !(waitMode && stopInWait))
      |=> $stable(preCnt) && $stable(modCnt));

  // R7: debug with its stop bit pauses the counters
  p_debug_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (debugActive && stopInDebug && !ctrlWr && !(waitMode && stopInWait))
      |=> $stable(preCnt) && $stable(modCnt));

  // R8: sticky flag, and a lone clear removes it
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tickFlag && !flagClr) |=> tickFlag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !periodEnd) |=> !tickFlag);

  // R9: a period end sets the flag even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> tickFlag);

  // R10: no request without the flag
  p_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> tickFlag);
endmodule

bind period_tick_gen period_tick_chk #(
  .PRE_W (PRE_W),
  .SEL_W (SEL_W),
  .MOD_W (MOD_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWr      (ctrlWr),
  .flagClr     (flagClr),
  .waitMode    (waitMode),
  .stopInWait  (stopInWait),
  .pseudoStop  (pseudoStop),
  .runInPseudo (runInPseudo),
  .debugActive (debugActive),
  .stopInDebug (stopInDebug),
  .periodEnd   (periodEnd),
  .tickFlag    (tickFlag),
  .irqReq      (irqReq),
  .ctrlSel     (ctrlSel),
  .ctrlMod     (ctrlMod),
  .preCnt      (preCnt),
  .modCnt      (modCnt)
);

// File: tb/period_tick_gen_tb_top.sv
module period_tick_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_LOG2  = 0;
  localparam int SEL_W      = 3;
  localparam int MOD_W      = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0;
  logic [SEL_W+MOD_W-1:0] ctrlData = '0;
  logic flagClr = 1'b0, irqEn = 1'b0;
  logic waitMode = 1'b0, stopInWait = 1'b0;
  logic pseudoStop = 1'b0, runInPseudo = 1'b0;
  logic debugActive = 1'b0, stopInDebug = 1'b0;
  logic tickFlag, irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  period_tick_gen #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W), .MOD_W(MOD_W)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .flagClr(flagClr), .irqEn(irqEn), .waitMode(waitMode), .stopInWait(stopInWait),
    .pseudoStop(pseudoStop), .runInPseudo(runInPseudo), .debugActive(debugActive),
    .stopInDebug(stopInDebug), .tickFlag(tickFlag), .irqReq(irqReq)
  );

  function automatic int periodOf(int sel, int m);
    return (m + 1) * (1 << (BASE_LOG2 + sel));
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Write a config, then clear the flag; returns at a negedge 1 edge after the write edge
  task automatic startCfg(int sel, int m);
    @(negedge clk);
    ctrlWr = 1'b1;
    ctrlData = {SEL_W'(sel), MOD_W'(m)};
    @(negedge clk);
    ctrlWr = 1'b0;
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  // Edges from now until tickFlag reads 1 (limit returns -1)
  task automatic countToFlag(output int n);
    n = -1;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (tickFlag) begin n = i; break; end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int n;
    int per;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flag in reset", int'(tickFlag), 0);
    check("R1 irq in reset", int'(irqReq), 0);
    rstN = 1'b1;
    steps(40);
    check("R1 parked after reset", int'(tickFlag), 0);

    // R2 parked with every modulus value
    for (int m = 0; m < 16; m++) begin
      startCfg(0, m);
      steps(20);
      check("R2 parked no flag", int'(tickFlag), 0);
    end

    // R3 full sweep of prescale and modulus codes (write edge counts as edge 0)
    for (int s = 1; s < 8; s++) begin
      for (int m = 0; m < 16; m++) begin
        startCfg(s, m);
        countToFlag(n);
        check($sformatf("R3 period s=%0d m=%0d", s, m), n + 1, periodOf(s, m));
      end
    end

    // R8 second period end keeps flag, lone clear removes it
    per = periodOf(2, 1);
    startCfg(2, 1);
    countToFlag(n);
    steps(per);
    check("R8 sticky over second end", int'(tickFlag), 1);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check("R8 lone clear", int'(tickFlag), 0);

    // R9 set and clear on the same edge (flag set at edge P, next end at edge 2P)
    per = periodOf(2, 2);
    startCfg(2, 2);
    countToFlag(n);          // now at edge P
    steps(per - 1);          // at edge 2P-1
    flagClr = 1'b1;
    @(negedge clk);          // edge 2P: end and clear together
    flagClr = 1'b0;
    check("R9 set wins", int'(tickFlag), 1);

    // R10 irq gating
    irqEn = 1'b0;
    #1 check("R10 irq masked", int'(irqReq), 0);
    irqEn = 1'b1;
    #1 check("R10 irq raised", int'(irqReq), 1);
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check("R10 irq follows clear", int'(irqReq), 0);
    irqEn = 1'b0;

    // R4 rewrite of the same value restarts the period
    per = periodOf(3, 3);
    startCfg(3, 3);
    steps(20);
    startCfg(3, 3);
    countToFlag(n);
    check("R4 restart on rewrite", n + 1, per);

    // R5 wait reset (elapsed 1 edge after startCfg)
    startCfg(3, 3);
    steps(9);
    waitMode = 1'b1; stopInWait = 1'b1;
    steps(5);
    waitMode = 1'b0; stopInWait = 1'b0;
    countToFlag(n);
    check("R5 wait resets counters", n, per);
    startCfg(3, 3);
    steps(9);
    waitMode = 1'b1;
    steps(5);
    waitMode = 1'b0;
    countToFlag(n);
    check("R5 wait without stop bit", n, per - 15);

    // R6 pseudo-stop freeze
    startCfg(3, 3);
    steps(9);
    pseudoStop = 1'b1;
    steps(7);
    pseudoStop = 1'b0;
    countToFlag(n);
    check("R6 freeze holds counters", n, per - 10);
    startCfg(3, 3);
    steps(9);
    pseudoStop = 1'b1; runInPseudo = 1'b1;
    steps(7);
    pseudoStop = 1'b0; runInPseudo = 1'b0;
    countToFlag(n);
    check("R6 run bit keeps counting", n, per - 17);

    // R7 debug pause
    startCfg(3, 3);
    steps(9);
    debugActive = 1'b1; stopInDebug = 1'b1;
    steps(7);
    debugActive = 1'b0; stopInDebug = 1'b0;
    countToFlag(n);
    check("R7 debug pause", n, per - 10);
    startCfg(3, 3);
    steps(9);
    debugActive = 1'b1;
    steps(7);
    debugActive = 1'b0;
    countToFlag(n);
    check("R7 debug without stop bit", n, per - 17);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule